// File: doc/BRIEF.md
# Encoded-Timeout Watchdog

This block is a watchdog timer whose whole setup is one byte. The low two bits choose a resolution step and the next five bits give a multiplier. The timeout is multiplier × 4^resolution periods of a 16 Hz tick, so the range runs from one tick up to 1984 ticks. The top bit chooses what happens when the count runs out. When it is set, expiry asks for a system reset and wipes the configuration. When it is clear, expiry raises a single interrupt pulse.

Software keeps the watchdog alive by touching the configuration byte. Writing it loads a new setup and restarts the count. Reading it returns the stored byte and restarts the count from that same setup. Every expiry sets a sticky watchdog flag, which stays set until the next write. After an expiry the counter stays idle until it is kicked again.

Top module: `wdog_enc_timer`

## Requirements
- R1: The configuration byte is laid out as steer = bit 7, multiplier m = bits 6:2 and resolution r = bits 1:0. After a kick, expiry happens on the (m × 4^r)-th tick pulse. Its output pulse is visible in the clock cycle that follows the edge at which that tick was sampled.
- R2: A configuration with m = 0 is disabled, whatever r is. This includes the all-zero byte. No tick then produces a reset request or an interrupt.
- R3: A write stores the byte, which reads back on `cfg_rdata`. It also clears the watchdog flag and restarts the countdown from the new value.
- R4: A read returns the stored byte and restarts the countdown from the stored value.
- R5: Every expiry sets `wdog_flag`. The flag stays set until the next write.
- R6: An expiry with steer = 1 gives a one-cycle `rst_req` pulse and a one-cycle `century_clr` pulse together. It also clears the stored configuration to 0x00.
- R7: An expiry with steer = 0 gives a one-cycle `irq` pulse. The stored configuration is left unchanged.
- R8: After an expiry the counter is idle. Further ticks produce no pulse until a write or read kicks it.
- R9: A kick in the same cycle as the final tick wins. No expiry occurs, and the full timeout is reloaded.
- R10: A write and a read in the same cycle act as a write. The written value is stored and used for the reload.
- R11: After synchronous reset, all outputs are 0, the stored configuration is 0x00, the flag is clear and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe (kick) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rd | input | 1 | Configuration read strobe (kick) |
| cfg_rdata | output | 8 | Stored configuration byte |
| tick_16hz | input | 1 | One-cycle pulse at 16 Hz |
| rst_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |
| century_clr | output | 1 | One-cycle request to clear the century bit elsewhere |
| wdog_flag | output | 1 | Sticky watchdog-expired flag |

## Verification
The final tick of a countdown can arrive in the same cycle as a kick, and then the kick and the expiry compete. The bench provokes this by asserting the read strobe and the tick together when exactly one tick remains. It then judges that no pulse appears and that the full timeout must elapse again before expiry. The second case of two functions in the same cycle is a write and a read strobed together over an older stored value. Here the bench checks that the stored byte and the next timeout come from the written value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    localparam int CFG_W  = 1 + MULT_W + RES_W;
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int TMO_W  = MULT_W + MAX_SHIFT;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdt_cfg_t;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_RESET = 2'd2
    } wdt_act_e;

    function automatic logic [TMO_W-1:0] tmo_ticks(input wdt_cfg_t c);
        logic [TMO_W-1:0] t;
        t = TMO_W'(c.mult);
        t = t << (2 * c.res);
        return t;
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     kick,
    input  wdt_cfg_t kick_cfg,
    input  logic     tick,
    output logic     expire,
    output logic     running
);

    cnt_state_e       state_q;
    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W-1:0] load_val;

    assign load_val = tmo_ticks(kick_cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CNT_IDLE;
            cnt_q   <= '0;
        end else if (kick) begin
            if (load_val == '0) begin
                state_q <= CNT_IDLE;
                cnt_q   <= '0;
            end else begin
                state_q <= CNT_RUN;
                cnt_q   <= load_val;
            end
        end else if (state_q == CNT_RUN && tick) begin
            if (cnt_q == TMO_W'(1)) begin
                state_q <= CNT_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q - TMO_W'(1);
            end
        end
    end

    assign expire  = (state_q == CNT_RUN) && tick && !kick && (cnt_q == TMO_W'(1));
    assign running = (state_q == CNT_RUN);

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == CNT_RUN) |-> (cnt_q != '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == CNT_IDLE && !kick) |=> (state_q == CNT_IDLE)); // R8
    AST_ZERO_MULT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (kick && kick_cfg.mult == '0) |=> (state_q == CNT_IDLE)); // R2

endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  wdt_cfg_t wdata,
    input  logic     expire,
    output wdt_cfg_t cfg_q,
    output logic     flag_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
        end else if (wr) begin
            cfg_q  <= wdata;
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
            if (cfg_q.steer) begin
                cfg_q <= '0;
            end
        end
    end

    AST_WRITE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr |=> !flag_q); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !wr) |=> flag_q); // R5

endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic steer,
    output logic rst_req,
    output logic irq,
    output logic century_clr
);

    wdt_act_e act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= ACT_NONE;
        end else if (expire) begin
            act_q <= steer ? ACT_RESET : ACT_IRQ;
        end else begin
            act_q <= ACT_NONE;
        end
    end

    assign rst_req     = (act_q == ACT_RESET);
    assign century_clr = (act_q == ACT_RESET);
    assign irq         = (act_q == ACT_IRQ);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (act_q != ACT_NONE) |=> (act_q == ACT_NONE)); // R6

endmodule

// File: rtl/wdog_enc_timer.sv
module wdog_enc_timer
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cfg_rd,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             tick_16hz,
    output logic             rst_req,
    output logic             irq,
    output logic             century_clr,
    output logic             wdog_flag
);

    wdt_cfg_t cfg_q;
    wdt_cfg_t wr_cfg;
    wdt_cfg_t kick_cfg;
    logic     kick;
    logic     expire;
    logic     running;

    assign wr_cfg   = wdt_cfg_t'(cfg_wdata);
    assign kick     = cfg_wr | cfg_rd;
    assign kick_cfg = cfg_wr ? wr_cfg : cfg_q;

    wdt_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (wr_cfg),
        .expire (expire),
        .cfg_q  (cfg_q),
        .flag_q (wdog_flag)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .kick     (kick),
        .kick_cfg (kick_cfg),
        .tick     (tick_16hz),
        .expire   (expire),
        .running  (running)
    );

    wdt_expiry u_exp (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .steer       (cfg_q.steer),
        .rst_req     (rst_req),
        .irq         (irq),
        .century_clr (century_clr)
    );

    assign cfg_rdata = CFG_W'(cfg_q);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, irq})); // R6
    AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
        (rst_req || irq) |-> wdog_flag); // R5
    AST_CFG_WIPED: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cfg_rdata == '0)); // R6
    AST_IRQ_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cfg_rdata == $past(cfg_rdata))); // R7
    AST_KICK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr || cfg_rd) |=> !(rst_req || irq)); // R9
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!running && !cfg_wr && !cfg_rd) |=> !(rst_req || irq)); // R8

endmodule

// File: tb/wdog_enc_timer_bench.sv
module wdog_enc_timer_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic       cfg_rd;
    logic [7:0] cfg_rdata;
    logic       tick_16hz;
    logic       rst_req;
    logic       irq;
    logic       century_clr;
    logic       wdog_flag;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk;

    wdog_enc_timer u_wdog_enc_timer (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rd      (cfg_rd),
        .cfg_rdata   (cfg_rdata),
        .tick_16hz   (tick_16hz),
        .rst_req     (rst_req),
        .irq         (irq),
        .century_clr (century_clr),
        .wdog_flag   (wdog_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic expect_pulses(input string req, input bit er, input bit ei);
        check({req, " rst_req"}, int'(rst_req), int'(er));
        check({req, " irq"}, int'(irq), int'(ei));
        check({req, " century_clr"}, int'(century_clr), int'(er));
    endtask

    function automatic int ticks_for(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    task automatic do_write(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_read();
        cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic do_tick();
        tick_16hz = 1'b1;
        @(negedge clk);
        tick_16hz = 1'b0;
    endtask

    task automatic idle_ticks(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            do_tick();
            expect_pulses(req, 1'b0, 1'b0);
            @(negedge clk);
        end
    endtask

    // R1 R5 R6 R7: full countdown for one configuration
    task automatic run_expiry(input logic [7:0] v);
        int n;
        n = ticks_for(v);
        do_write(v);
        check("R3 readback", int'(cfg_rdata), int'(v));
        check("R3 flag cleared", int'(wdog_flag), 0);
        idle_ticks("R1 early", n - 1);
        do_tick();
        expect_pulses(v[7] ? "R6 expiry" : "R7 expiry", v[7], !v[7]);
        check("R5 flag set", int'(wdog_flag), 1);
        check(v[7] ? "R6 cfg wiped" : "R7 cfg kept", int'(cfg_rdata), v[7] ? 0 : int'(v));
        @(negedge clk);
        expect_pulses("R6 R7 single cycle", 1'b0, 1'b0);
        check("R5 flag sticky", int'(wdog_flag), 1);
    endtask

    task automatic t_reset();
        check("R11 rst_req", int'(rst_req), 0);
        check("R11 irq", int'(irq), 0);
        check("R11 century_clr", int'(century_clr), 0);
        check("R11 cfg", int'(cfg_rdata), 0);
        check("R11 flag", int'(wdog_flag), 0);
        idle_ticks("R11 idle", 3);
    endtask

    task automatic t_disabled();
        do_write(8'h00);
        idle_ticks("R2 zero cfg", 10);
        do_write(8'h03);
        idle_ticks("R2 m0 r3", 10);
        do_write(8'h81);
        do_read();
        idle_ticks("R2 m0 steer", 10);
    endtask

    task automatic t_irq_modes();
        run_expiry(8'h05);
        idle_ticks("R8 idle after irq", 6);
        run_expiry(8'h0C);
        run_expiry(8'h0A);
        run_expiry(8'h04);
    endtask

    task automatic t_reset_mode();
        run_expiry(8'h88);
        do_read();
        idle_ticks("R8 idle after reset", 6);
    endtask

    task automatic t_read_kick();
        do_write(8'h0C);
        idle_ticks("R4 pre-read", 2);
        do_read();
        check("R4 read data", int'(cfg_rdata), 8'h0C);
        idle_ticks("R4 reloaded", 2);
        do_tick();
        expect_pulses("R4 expiry after read", 1'b0, 1'b1);
        @(negedge clk);
        do_read();
        idle_ticks("R4 rearmed", 2);
        do_tick();
        expect_pulses("R4 rearm expiry", 1'b0, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_kick_collide();
        do_write(8'h08);
        idle_ticks("R9 first", 1);
        cfg_rd = 1'b1; tick_16hz = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0; tick_16hz = 1'b0;
        expect_pulses("R9 collide", 1'b0, 1'b0);
        @(negedge clk);
        expect_pulses("R9 collide next", 1'b0, 1'b0);
        idle_ticks("R9 reloaded", 1);
        do_tick();
        expect_pulses("R9 late expiry", 1'b0, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_wr_rd_same();
        do_write(8'h0C);
        cfg_wr = 1'b1; cfg_rd = 1'b1; cfg_wdata = 8'h04;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_rd = 1'b0;
        check("R10 stored", int'(cfg_rdata), 8'h04);
        do_tick();
        expect_pulses("R10 one tick", 1'b0, 1'b1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_rd = 1'b0; cfg_wdata = '0; tick_16hz = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_irq_modes();
        t_reset_mode();
        t_read_kick();
        t_kick_collide();
        t_wr_rd_same();
        finish_run();
    end

endmodule